// File: doc/BRIEF.md
# Static Memory Data-Float Wait Controller

This block sequences accesses on an external static memory bus. It handles the turnaround time after a read. Once the read strobe is released, the memory may keep driving the shared data bus for a programmable number of cycles. The controller therefore keeps a float counter. It loads that count at the end of every read strobe and runs it down one step per clock. The counter overlaps the read hold phase and the write setup phase of the next access. An extra wait cycle is inserted only when that overlap falls short.

Each chip select has four settings: a float length, an optimization flag, a number of read hold cycles and a number of write setup cycles. The optimization flag decides where the remaining float time is paid:

- **Flag clear:** the remaining float time is paid at the tail of the read itself, with the request port closed.
- **Flag set:** the port reopens right after the hold phase. The next access waits only for the float time it actually needs.

Each access ends with a one-cycle done pulse. The pulse carries the number of float wait cycles charged to that access.

Top module: `smc_float_ctrl`

## Requirements
- R1: After reset `req_ready_o` is 1, every bit of `cs_n_o` is 1, `rd_n_o` and `wr_n_o` are 1 and `done_o` is 0.
- R2: A read drives `rd_n_o` low for exactly one cycle. `cs_n_o` of the selected chip select then stays low for that chip select's hold count of cycles. Only one `cs_n_o` bit is ever low, and the two strobes are never low together.
- R3: With the optimization flag of the read's chip select at 0, the port stays closed after the hold phase for max(0, float − hold) cycles with all chip selects released. Those cycles are reported as the read's wait count.
- R4: When the hold count is at least the float count, no tail cycles follow a read and the read's wait count is 0.
- R5: With the optimization flag at 1, the port reopens right after the hold phase. The next access then holds back its strobe until the float counter is zero. Its wait count is the number of cycles it waited beyond its own setup (and turnaround) time.
- R6: With the optimization flag at 1, a read on the same chip select as the preceding read asserts its strobe in its first active cycle, whatever float time remains.
- R7: A write keeps its chip select low for its setup count of cycles before `wr_n_o` goes low. One turnaround cycle is added when the previous strobe was a read. These cycles count toward the float time.
- R8: `wr_n_o` never goes low while float time from a preceding read remains.
- R9: `done_o` is a one-cycle pulse in the cycle after an access finishes. `wait_cnt_o` holds that access's float wait count while `done_o` is 1.
- R10: A request is taken when `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 1 only while no access, hold phase or float wait is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_float_i | input | N_CS*CNT_W (8) | Float cycle count per chip select, chip select k at bits [k*CNT_W +: CNT_W] |
| cfg_opt_i | input | N_CS (2) | Float optimization flag per chip select |
| cfg_hold_i | input | N_CS*CNT_W (8) | Read hold cycles per chip select |
| cfg_setup_i | input | N_CS*CNT_W (8) | Write setup cycles per chip select |
| req_valid_i | input | 1 | Access request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W (1) | Chip select index of the request |
| req_ready_o | output | 1 | Request accepted when high with valid |
| cs_n_o | output | N_CS (2) | Chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| done_o | output | 1 | Access finished pulse |
| wait_cnt_o | output | CNT_W+1 (5) | Float wait cycles charged to the finished access |

## Verification
Two things can fall due in the same cycle: the end of a write's setup (plus turnaround) time and the expiry of the float counter left by a preceding read. The write strobe may only assert once both are over.

The bench provokes this by issuing a write right after a read, on the same or the other chip select. It uses float, hold and setup values chosen so that either limit can be the later one. It also covers the case where the two land exactly together.

It judges each case on two measures:
- the cycle distance between the read strobe and the write strobe;
- the wait count reported for each access.

Both are compared with values computed from the settings. An assertion also guards the rule that the write strobe never falls while float time remains.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_HOLD = 2'd2,
    ST_TAIL = 2'd3
  } smc_state_e;
endpackage

// File: rtl/smc_cfg_sel.sv
module smc_cfg_sel #(
  parameter int N_CS  = 2,
  parameter int CNT_W = 4,
  parameter int CS_W  = 1
) (
  input  logic [N_CS*CNT_W-1:0] cfg_float_i,
  input  logic [N_CS-1:0]       cfg_opt_i,
  input  logic [N_CS*CNT_W-1:0] cfg_hold_i,
  input  logic [N_CS*CNT_W-1:0] cfg_setup_i,
  input  logic [CS_W-1:0]       sel_i,
  output logic [CNT_W-1:0]      float_o,
  output logic                  opt_o,
  output logic [CNT_W-1:0]      hold_o,
  output logic [CNT_W-1:0]      setup_o
);
  logic [CNT_W-1:0] float_a [N_CS];
  logic [CNT_W-1:0] hold_a  [N_CS];
  logic [CNT_W-1:0] setup_a [N_CS];

  for (genvar g = 0; g < N_CS; g++) begin : g_unpack
    assign float_a[g] = cfg_float_i[g*CNT_W +: CNT_W];
    assign hold_a[g]  = cfg_hold_i[g*CNT_W +: CNT_W];
    assign setup_a[g] = cfg_setup_i[g*CNT_W +: CNT_W];
  end

  assign float_o = float_a[sel_i];
  assign hold_o  = hold_a[sel_i];
  assign setup_o = setup_a[sel_i];
  assign opt_o   = cfg_opt_i[sel_i];
endmodule

// File: rtl/smc_float_ctr.sv
module smc_float_ctr #(
  parameter int CNT_W = 4,
  parameter int CS_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,      // read strobe this cycle
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CS_W-1:0]  load_cs_i,
  input  logic             load_opt_i,
  input  logic             wr_stb_i,
  output logic [CNT_W-1:0] fc_o,
  output logic [CS_W-1:0]  own_cs_o,
  output logic             own_opt_o,
  output logic             last_rd_o
);
  logic [CNT_W-1:0] fc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q      <= '0;
      own_cs_o  <= '0;
      own_opt_o <= 1'b0;
      last_rd_o <= 1'b0;
    end else begin
      if (load_i) begin
        fc_q      <= load_val_i;
        own_cs_o  <= load_cs_i;
        own_opt_o <= load_opt_i;
        last_rd_o <= 1'b1;
      end else begin
        if (fc_q != '0) fc_q <= fc_q - 1'b1;
        if (wr_stb_i) last_rd_o <= 1'b0;
      end
    end
  end

  assign fc_o = fc_q;

  // R5
  float_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> fc_q <= $past(fc_q));
endmodule

// File: rtl/smc_phase_fsm.sv
module smc_phase_fsm
  import smc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int CS_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [CS_W-1:0]  req_cs_i,
  input  logic [CNT_W-1:0] float_i,
  input  logic             opt_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] fc_i,
  input  logic [CS_W-1:0]  own_cs_i,
  input  logic             own_opt_i,
  input  logic             last_rd_i,
  output logic             ready_o,
  output logic             active_o,
  output logic [CS_W-1:0]  cs_o,
  output logic             rd_stb_o,
  output logic             wr_stb_o,
  output logic             done_o,
  output logic [CNT_W:0]   wait_cnt_o
);
  smc_state_e       st_q, st_d;
  logic [CS_W-1:0]  cs_q;
  logic             wr_q;
  logic [CNT_W:0]   cnt_q, acc_q, wait_q, base, wait_nxt;
  logic [CNT_W-1:0] fc_dec;
  logic             base_met, exempt, block, go, inc, fin, accept, hold_end;

  assign accept   = (st_q == ST_IDLE) && req_valid_i;
  assign base     = wr_q ? ({1'b0, setup_i} + {{CNT_W{1'b0}}, last_rd_i}) : '0;
  assign base_met = cnt_q >= base;
  // same-cs read under optimization may ignore leftover float time
  assign exempt   = own_opt_i && (own_cs_i == cs_q) && !wr_q;
  assign block    = (fc_i != '0) && !exempt;
  assign go       = (st_q == ST_ACT) && base_met && !block;
  assign fc_dec   = (fc_i == '0) ? '0 : fc_i - 1'b1;
  assign hold_end = (st_q == ST_HOLD) && (cnt_q == ({1'b0, hold_i} - 1'b1));
  assign inc      = ((st_q == ST_ACT) && base_met && block) || (st_q == ST_TAIL);
  assign wait_nxt = acc_q + {{CNT_W{1'b0}}, inc};

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_ACT;
      ST_ACT: if (go) begin
        if (wr_q) begin
          st_d = ST_IDLE; fin = 1'b1;
        end else if (hold_i != '0) begin
          st_d = ST_HOLD;
        end else if (!opt_i && float_i != '0) begin
          st_d = ST_TAIL;
        end else begin
          st_d = ST_IDLE; fin = 1'b1;
        end
      end
      ST_HOLD: if (hold_end) begin
        if (!opt_i && fc_dec != '0) st_d = ST_TAIL;
        else begin st_d = ST_IDLE; fin = 1'b1; end
      end
      ST_TAIL: if (fc_i <= CNT_W'(1)) begin
        st_d = ST_IDLE; fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cs_q   <= '0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      wait_q <= '0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= fin;
      if (fin) wait_q <= wait_nxt;
      if (accept) begin
        cs_q  <= req_cs_i;
        wr_q  <= req_write_i;
        cnt_q <= '0;
        acc_q <= '0;
      end else begin
        acc_q <= wait_nxt;
        if (st_q == ST_ACT) begin
          if (go) cnt_q <= '0;
          else if (!base_met) cnt_q <= cnt_q + 1'b1;
        end else if (st_q == ST_HOLD) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign ready_o    = (st_q == ST_IDLE);
  assign active_o   = (st_q == ST_ACT) || (st_q == ST_HOLD);
  assign cs_o       = cs_q;
  assign rd_stb_o   = go && !wr_q;
  assign wr_stb_o   = go && wr_q;
  assign wait_cnt_o = wait_q;

  // R3
  tail_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL) |-> fc_i != '0);
  // R10
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_valid_i) |=> !ready_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_o |=> !rd_stb_o);
endmodule

// File: rtl/smc_float_ctrl.sv
module smc_float_ctrl #(
  parameter int N_CS  = 2,
  parameter int CNT_W = 4,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CS*CNT_W-1:0] cfg_float_i,
  input  logic [N_CS-1:0]       cfg_opt_i,
  input  logic [N_CS*CNT_W-1:0] cfg_hold_i,
  input  logic [N_CS*CNT_W-1:0] cfg_setup_i,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [CS_W-1:0]       req_cs_i,
  output logic                  req_ready_o,
  output logic [N_CS-1:0]       cs_n_o,
  output logic                  rd_n_o,
  output logic                  wr_n_o,
  output logic                  done_o,
  output logic [CNT_W:0]        wait_cnt_o
);
  logic [CNT_W-1:0] float_s, hold_s, setup_s, fc;
  logic             opt_s, own_opt, last_rd, active, rd_stb, wr_stb;
  logic [CS_W-1:0]  cur_cs, own_cs;

  smc_cfg_sel #(.N_CS(N_CS), .CNT_W(CNT_W), .CS_W(CS_W)) u_sel (
    .cfg_float_i (cfg_float_i),
    .cfg_opt_i   (cfg_opt_i),
    .cfg_hold_i  (cfg_hold_i),
    .cfg_setup_i (cfg_setup_i),
    .sel_i       (cur_cs),
    .float_o     (float_s),
    .opt_o       (opt_s),
    .hold_o      (hold_s),
    .setup_o     (setup_s)
  );

  smc_float_ctr #(.CNT_W(CNT_W), .CS_W(CS_W)) u_fc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rd_stb),
    .load_val_i (float_s),
    .load_cs_i  (cur_cs),
    .load_opt_i (opt_s),
    .wr_stb_i   (wr_stb),
    .fc_o       (fc),
    .own_cs_o   (own_cs),
    .own_opt_o  (own_opt),
    .last_rd_o  (last_rd)
  );

  smc_phase_fsm #(.CNT_W(CNT_W), .CS_W(CS_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_cs_i    (req_cs_i),
    .float_i     (float_s),
    .opt_i       (opt_s),
    .hold_i      (hold_s),
    .setup_i     (setup_s),
    .fc_i        (fc),
    .own_cs_i    (own_cs),
    .own_opt_i   (own_opt),
    .last_rd_i   (last_rd),
    .ready_o     (req_ready_o),
    .active_o    (active),
    .cs_o        (cur_cs),
    .rd_stb_o    (rd_stb),
    .wr_stb_o    (wr_stb),
    .done_o      (done_o),
    .wait_cnt_o  (wait_cnt_o)
  );

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(active && (cur_cs == CS_W'(g)));
  end

  assign rd_n_o = !rd_stb;
  assign wr_n_o = !wr_stb;

  // R8
  wr_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> fc == '0);
  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R2
  stb_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
endmodule

// File: tb/smc_float_ctrl_tb.sv
module smc_float_ctrl_tb;
  localparam int N_CS = 2;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic [3:0] h, t, s;
    logic o0, o1, a_cs, b_cs, b_wr;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 4'd6,  4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd4, 4'd6,  4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd4, 4'd6,  4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{4'd4, 4'd6,  4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd4, 4'd6,  4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd4, 4'd6,  4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd2, 4'd12, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd2, 4'd12, 4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd2, 4'd12, 4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd6, 4'd6,  4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd2, 4'd12, 4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd0, 4'd5,  4'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{4'd0, 4'd3,  4'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{4'd4, 4'd6,  4'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_CS*CNT_W-1:0] cfg_float, cfg_hold, cfg_setup;
  logic [N_CS-1:0] cfg_opt;
  logic req_valid = 1'b0, req_write = 1'b0, req_cs = 1'b0;
  logic ready, rd_n, wr_n, done;
  logic [N_CS-1:0] cs_n;
  logic [CNT_W:0] wait_cnt;

  int cyc = 0, n_chk = 0, n_fail = 0, nstr = 0, ndone = 0, issue_cyc = 0;
  int stb_log [4];
  int w_log [4];
  bit finished = 1'b0;

  always #2 clk = ~clk;

  smc_float_ctrl #(.N_CS(N_CS), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_float_i(cfg_float), .cfg_opt_i(cfg_opt),
    .cfg_hold_i(cfg_hold), .cfg_setup_i(cfg_setup),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_cs_i(req_cs),
    .req_ready_o(ready), .cs_n_o(cs_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .done_o(done), .wait_cnt_o(wait_cnt)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (!rd_n || !wr_n) begin
      if (nstr < 4) stb_log[nstr] = cyc;
      nstr = nstr + 1;
    end
    if (done) begin
      if (ndone < 4) w_log[ndone] = int'(wait_cnt);
      ndone = ndone + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic cs, input logic wr);
    req_cs = cs; req_write = wr; req_valid = 1'b1;
    while (!ready) @(negedge clk);
    issue_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_float = {v.t, v.t};
    cfg_hold  = {v.h, v.h};
    cfg_setup = {v.s, v.s};
    cfg_opt   = {v.o1, v.o0};
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  initial begin
    set_cfg(VECS[0]);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready === 1'b1 && cs_n === 2'b11 && rd_n === 1'b1 && wr_n === 1'b1 && done === 1'b0,
          "R1 reset outputs", int'({ready, cs_n, rd_n, wr_n, done}), 6'b111110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // stimulus table: read A then B at once
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int h, t, s, opt_a, opt_b, tail_a, f0, base, k, actw, tail_b, gap;
      bit exempt;
      v = VECS[i];
      set_cfg(v);
      h = int'(v.h); t = int'(v.t); s = int'(v.s);
      opt_a = v.a_cs ? int'(v.o1) : int'(v.o0);
      opt_b = v.b_cs ? int'(v.o1) : int'(v.o0);
      tail_a = opt_a ? 0 : mx(0, t - h);
      f0 = opt_a ? mx(0, t - h - 1) : 0;
      base = v.b_wr ? s + 1 : 0;
      exempt = (opt_a != 0) && (v.b_cs == v.a_cs) && !v.b_wr;
      k = exempt ? base : mx(base, f0);
      actw = k - base;
      tail_b = (v.b_wr || opt_b != 0) ? 0 : mx(0, t - h);
      gap = h + tail_a + 2 + k;
      nstr = 0; ndone = 0;
      issue(v.a_cs, 1'b0);
      issue(v.b_cs, v.b_wr);
      while (ndone < 2) @(negedge clk);
      // R3 / R4 / R9 read wait report
      check(w_log[0] == tail_a, (opt_a != 0) ? "R5 read A waits" : (h >= t) ? "R4 read A waits" : "R3 read A waits",
            w_log[0], tail_a);
      // R5 / R6 / R7 / R8 second access waits
      check(w_log[1] == actw + tail_b, exempt ? "R6 access B waits" : v.b_wr ? "R7 access B waits" : "R5 access B waits",
            w_log[1], actw + tail_b);
      // R2 strobe spacing
      check(stb_log[1] - stb_log[0] == gap, "R2 strobe gap", stb_log[1] - stb_log[0], gap);
      repeat (40) @(negedge clk);
    end

    // R7 turnaround after a read, long idle before
    set_cfg(VECS[0]);
    nstr = 0; ndone = 0;
    issue(1'b1, 1'b0);
    repeat (40) @(negedge clk);
    nstr = 0;
    issue(1'b0, 1'b1);
    // R10 port closed right after accept
    check(ready === 1'b0, "R10 ready after accept", int'(ready), 0);
    while (nstr < 1) @(negedge clk);
    check(stb_log[0] - issue_cyc == 5, "R7 write after read", stb_log[0] - issue_cyc, 5);
    repeat (5) @(negedge clk);
    nstr = 0;
    issue(1'b0, 1'b1);
    while (nstr < 1) @(negedge clk);
    check(stb_log[0] - issue_cyc == 4, "R7 write after write", stb_log[0] - issue_cyc, 4);
    repeat (5) @(negedge clk);
    // R10 ready back when idle
    check(ready === 1'b1, "R10 ready idle", int'(ready), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule